// File: doc/BRIEF.md
# Floating-Point Register Rename Table

This block sits beside the floating-point register file of an out-of-order core. For every architectural register it keeps the register's current value and a producer tag. The tag names the reservation station that will write the register next. Tag zero means no station is pending and the stored value is current. When an instruction issues, the block reads both source registers. For each one it returns either the stored value or the tag of the station that will produce it. In the same step it records the issuing station as the new producer of the destination register. Because every issue overwrites the destination's tag, a station that has been superseded can never write the register. Results from later writers are never lost to earlier ones, so write-after-write and write-after-read hazards on the register file go away.

The block also watches the result broadcast bus. A broadcast carries a station tag and a data word. Every register whose recorded producer equals that tag takes the data and goes back to blank status. An issue that reads such a register in the same cycle as its broadcast gets the broadcast data directly. Instruction decode, the stations and the execution units are outside this block.

Top module: `fp_rename_table`

## Requirements
- R1: After synchronous reset, every register has blank status (tag 0) and value 0, and `rd_valid` is low.
- R2: Issue results are registered. The cycle after an edge that samples `issue_valid` high, `rd_valid` is high and the read results are present. After an edge with `issue_valid` low, `rd_valid` is low and the read results hold their previous values.
- R3: A source register with blank status returns its stored value on the value output, and 0 on the tag output.
- R4: A source register with a non-zero status returns that status on the tag output, and 0 on the value output.
- R5: At the issue edge, the destination's status becomes `issue_tag`, replacing any earlier producer. The sources of that same issue see the status as it was before this update.
- R6: A broadcast with a non-zero tag that equals a register's status writes `bcast_data` into that register at that edge and clears its status to 0. Issues from the next cycle on see the new value.
- R7: A register whose status differs from the broadcast tag keeps its value and its status. In particular, the result of a superseded producer is never written.
- R8: If an issue names a register as its destination in the same cycle that a matching broadcast arrives for that register, the status takes the new issue tag and is not cleared.
- R9: A source read at an issue edge where a matching broadcast is also applied returns `bcast_data` and tag 0.
- R10: A broadcast with tag 0 is ignored. It changes no value and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_src_a | input | IDX_W | First source register index |
| issue_src_b | input | IDX_W | Second source register index |
| issue_dst | input | IDX_W | Destination register index |
| issue_tag | input | TAG_W | Station tag of the issuing instruction |
| bcast_valid | input | 1 | A result is on the broadcast bus |
| bcast_tag | input | TAG_W | Station that produced the broadcast result |
| bcast_data | input | DATA_W | Broadcast result value |
| rd_valid | output | 1 | Read results of the previous issue are present |
| rd_a_value | output | DATA_W | First source value (0 when pending) |
| rd_a_tag | output | TAG_W | First source producer tag (0 when ready) |
| rd_b_value | output | DATA_W | Second source value (0 when pending) |
| rd_b_tag | output | TAG_W | Second source producer tag (0 when ready) |

## Verification
The main function is exercised with four patterns:
- A single producer followed by its broadcast separates a ready value from a pending tag.
- Two producers for one register, with the older one broadcasting first, separates tag replacement from a plain last-write-wins bank.
- Two registers waiting on different tags while only one broadcasts shows that a write is matched per register and not applied to all of them.
- A broadcast coinciding with either a read or a re-issue of the same register tells the same-cycle bypass apart from a one-cycle-late update, and shows whether a new tag wins over a clear.

A zero-tag broadcast and an instruction that reads its own destination cover the two cases where a careless match or ordering would corrupt ready registers.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rrs_tag_store.sv
module rrs_tag_store #(
  parameter int NREG  = 16,
  parameter int TAG_W = 4,
  localparam int IDX_W = rrs_pkg::idx_w(NREG)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        issue_valid,
  input  logic [IDX_W-1:0]            issue_dst,
  input  logic [TAG_W-1:0]            issue_tag,
  input  logic                        bcast_valid,
  input  logic [TAG_W-1:0]            bcast_tag,
  output logic [NREG-1:0][TAG_W-1:0]  tag_q,
  output logic [NREG-1:0]             hit
);
  logic bcast_live;
  assign bcast_live = bcast_valid && (bcast_tag != '0);

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    logic claim;
    assign claim  = issue_valid && (issue_dst == IDX_W'(i));
    assign hit[i] = bcast_live && (tag_q[i] == bcast_tag);

    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[i] <= '0;
      end else if (claim) begin
        tag_q[i] <= issue_tag;
      end else if (hit[i]) begin
        tag_q[i] <= '0;
      end
    end
  end
endmodule

// File: rtl/rrs_value_bank.sv
module rrs_value_bank #(
  parameter int NREG   = 16,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NREG-1:0]              wr_mask,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NREG-1:0][DATA_W-1:0]  value_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        value_q[i] <= '0;
      end else if (wr_mask[i]) begin
        value_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rrs_src_read.sv
module rrs_src_read #(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  localparam int IDX_W = rrs_pkg::idx_w(NREG)
) (
  input  logic [IDX_W-1:0]             idx,
  input  logic [NREG-1:0][TAG_W-1:0]   tag_q,
  input  logic [NREG-1:0]              hit,
  input  logic [NREG-1:0][DATA_W-1:0]  value_q,
  input  logic [DATA_W-1:0]            bcast_data,
  output logic [DATA_W-1:0]            value,
  output logic [TAG_W-1:0]             tag
);
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_val;
  logic              sel_hit;

  always_comb begin
    sel_tag = '0;
    sel_val = '0;
    sel_hit = 1'b0;
    if (int'(idx) < NREG) begin
      sel_tag = tag_q[idx];
      sel_val = value_q[idx];
      sel_hit = hit[idx];
    end
  end

  always_comb begin
    if (sel_hit) begin
      value = bcast_data;
      tag   = '0;
    end else if (sel_tag != '0) begin
      value = '0;
      tag   = sel_tag;
    end else begin
      value = sel_val;
      tag   = '0;
    end
  end
endmodule

// File: rtl/fp_rename_table.sv
module fp_rename_table #(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  localparam int IDX_W = rrs_pkg::idx_w(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [IDX_W-1:0]  issue_src_a,
  input  logic [IDX_W-1:0]  issue_src_b,
  input  logic [IDX_W-1:0]  issue_dst,
  input  logic [TAG_W-1:0]  issue_tag,
  input  logic              bcast_valid,
  input  logic [TAG_W-1:0]  bcast_tag,
  input  logic [DATA_W-1:0] bcast_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_a_value,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [DATA_W-1:0] rd_b_value,
  output logic [TAG_W-1:0]  rd_b_tag
);
  localparam int NSRC = 2;

  logic [NREG-1:0][TAG_W-1:0]  tag_q;
  logic [NREG-1:0]             hit;
  logic [NREG-1:0][DATA_W-1:0] value_q;

  logic [NSRC-1:0][IDX_W-1:0]  src_idx;
  logic [NSRC-1:0][DATA_W-1:0] src_val;
  logic [NSRC-1:0][TAG_W-1:0]  src_tag;

  assign src_idx[0] = issue_src_a;
  assign src_idx[1] = issue_src_b;

  rrs_tag_store #(.NREG(NREG), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst(rst),
    .issue_valid(issue_valid), .issue_dst(issue_dst), .issue_tag(issue_tag),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
    .tag_q(tag_q), .hit(hit)
  );

  rrs_value_bank #(.NREG(NREG), .DATA_W(DATA_W)) bank_i (
    .clk(clk), .rst(rst),
    .wr_mask(hit), .wr_data(bcast_data),
    .value_q(value_q)
  );

  for (genvar p = 0; p < NSRC; p++) begin : g_src
    rrs_src_read #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) rd_i (
      .idx(src_idx[p]), .tag_q(tag_q), .hit(hit), .value_q(value_q),
      .bcast_data(bcast_data), .value(src_val[p]), .tag(src_tag[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_a_value <= '0;
      rd_a_tag   <= '0;
      rd_b_value <= '0;
      rd_b_tag   <= '0;
    end else begin
      rd_valid <= issue_valid;
      if (issue_valid) begin
        rd_a_value <= src_val[0];
        rd_a_tag   <= src_tag[0];
        rd_b_value <= src_val[1];
        rd_b_tag   <= src_tag[1];
      end
    end
  end
endmodule

// File: rtl/fp_rename_table_chk.sv
module fp_rename_table_chk #(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  localparam int IDX_W = rrs_pkg::idx_w(NREG)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       issue_valid,
  input logic [IDX_W-1:0]           issue_dst,
  input logic [TAG_W-1:0]           issue_tag,
  input logic                       bcast_valid,
  input logic [TAG_W-1:0]           bcast_tag,
  input logic [NREG-1:0][TAG_W-1:0] tag_q,
  input logic                       rd_valid,
  input logic [DATA_W-1:0]          rd_a_value,
  input logic [TAG_W-1:0]           rd_a_tag,
  input logic [DATA_W-1:0]          rd_b_value,
  input logic [TAG_W-1:0]           rd_b_tag
);
  p_reset_blank_r1: assert property (@(posedge clk) rst |=> (tag_q == '0) && !rd_valid);

  p_rd_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> rd_valid);
  p_rd_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> !rd_valid && $stable(rd_a_value) && $stable(rd_b_tag));

  p_tag_excl_a_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_a_tag != '0) |-> (rd_a_value == '0));
  p_tag_excl_b_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_b_tag != '0) |-> (rd_b_value == '0));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    p_dst_claim_r5: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && issue_dst == IDX_W'(i)) |=> (tag_q[i] == $past(issue_tag)));
    p_match_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (bcast_valid && bcast_tag != '0 && tag_q[i] == bcast_tag &&
       !(issue_valid && issue_dst == IDX_W'(i))) |=> (tag_q[i] == '0));
    p_stale_keep_r7: assert property (@(posedge clk) disable iff (rst)
      (bcast_valid && tag_q[i] != bcast_tag &&
       !(issue_valid && issue_dst == IDX_W'(i))) |=> $stable(tag_q[i]));
    p_zero_bcast_r10: assert property (@(posedge clk) disable iff (rst)
      (bcast_valid && bcast_tag == '0 &&
       !(issue_valid && issue_dst == IDX_W'(i))) |=> $stable(tag_q[i]));
  end
endmodule

bind fp_rename_table fp_rename_table_chk #(
  .NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)
) chk_i (
  .clk(clk), .rst(rst),
  .issue_valid(issue_valid), .issue_dst(issue_dst), .issue_tag(issue_tag),
  .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
  .tag_q(tag_q),
  .rd_valid(rd_valid),
  .rd_a_value(rd_a_value), .rd_a_tag(rd_a_tag),
  .rd_b_value(rd_b_value), .rd_b_tag(rd_b_tag)
);

// File: tb/fp_rename_table_tb_top.sv
`timescale 1ns/1ps
module fp_rename_table_tb_top;
  localparam int NREG = 16, DATA_W = 32, TAG_W = 4, IDX_W = 4;
  localparam logic [IDX_W-1:0] SCR = 4'd15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_valid = 1'b0, bcast_valid = 1'b0;
  logic [IDX_W-1:0] issue_src_a = '0, issue_src_b = '0, issue_dst = '0;
  logic [TAG_W-1:0] issue_tag = '0, bcast_tag = '0;
  logic [DATA_W-1:0] bcast_data = '0;
  logic rd_valid;
  logic [DATA_W-1:0] rd_a_value, rd_b_value;
  logic [TAG_W-1:0] rd_a_tag, rd_b_tag;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_rename_table #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut_i (.*);

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(bit iv, logic [IDX_W-1:0] sa, logic [IDX_W-1:0] sb,
                       logic [IDX_W-1:0] dst, logic [TAG_W-1:0] tg,
                       bit bv, logic [TAG_W-1:0] bt, logic [DATA_W-1:0] bd);
    @(negedge clk);
    issue_valid = iv; issue_src_a = sa; issue_src_b = sb;
    issue_dst = dst; issue_tag = tg;
    bcast_valid = bv; bcast_tag = bt; bcast_data = bd;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(0, '0, '0, '0, '0, 0, '0, '0);
  endtask

  task automatic read2(logic [IDX_W-1:0] ra, logic [IDX_W-1:0] rb);
    drive(1, ra, rb, SCR, '0, 0, '0, '0);
  endtask

  task automatic expect_src(string req, logic [31:0] av, logic [31:0] at,
                            logic [31:0] bv, logic [31:0] bt);
    check_eq(req, "rd_valid", 32'(rd_valid), 32'd1);
    check_eq(req, "a.value", rd_a_value, av);
    check_eq(req, "a.tag", 32'(rd_a_tag), at);
    check_eq(req, "b.value", rd_b_value, bv);
    check_eq(req, "b.tag", 32'(rd_b_tag), bt);
  endtask

  task automatic t_reset();
    check_eq("R1", "rd_valid after reset", 32'(rd_valid), 32'd0);
    read2(4'd1, 4'd2);
    expect_src("R1", 0, 0, 0, 0);
    idle();
    check_eq("R2", "rd_valid drops", 32'(rd_valid), 32'd0);
    check_eq("R2", "a.value held", rd_a_value, 32'd0);
  endtask

  task automatic t_single_producer();
    drive(1, 4'd0, 4'd0, 4'd3, 4'd5, 0, '0, '0);
    read2(4'd3, 4'd0);
    expect_src("R4", 0, 5, 0, 0);
    drive(0, '0, '0, '0, '0, 1, 4'd5, 32'h0000_AAAA);
    read2(4'd3, 4'd3);
    expect_src("R6", 32'h0000_AAAA, 0, 32'h0000_AAAA, 0);
    read2(4'd3, 4'd1);
    expect_src("R3", 32'h0000_AAAA, 0, 0, 0);
  endtask

  task automatic t_waw();
    drive(1, 4'd0, 4'd0, 4'd4, 4'd6, 0, '0, '0);
    drive(1, 4'd0, 4'd0, 4'd4, 4'd7, 0, '0, '0);
    drive(0, '0, '0, '0, '0, 1, 4'd6, 32'h1111_1111);
    read2(4'd4, 4'd4);
    expect_src("R7", 0, 7, 0, 7);
    drive(0, '0, '0, '0, '0, 1, 4'd7, 32'h2222_2222);
    read2(4'd4, 4'd0);
    expect_src("R5", 32'h2222_2222, 0, 0, 0);
  endtask

  task automatic t_bypass();
    drive(1, 4'd0, 4'd0, 4'd5, 4'd8, 0, '0, '0);
    drive(1, 4'd5, 4'd4, SCR, 4'd0, 1, 4'd8, 32'h3333_3333);
    expect_src("R9", 32'h3333_3333, 0, 32'h2222_2222, 0);
    read2(4'd5, 4'd5);
    expect_src("R9", 32'h3333_3333, 0, 32'h3333_3333, 0);
  endtask

  task automatic t_issue_vs_bcast();
    drive(1, 4'd0, 4'd0, 4'd6, 4'd9, 0, '0, '0);
    drive(1, 4'd0, 4'd0, 4'd6, 4'd10, 1, 4'd9, 32'h4444_4444);
    read2(4'd6, 4'd0);
    expect_src("R8", 0, 10, 0, 0);
    drive(0, '0, '0, '0, '0, 1, 4'd10, 32'h5555_5555);
    read2(4'd6, 4'd0);
    expect_src("R8", 32'h5555_5555, 0, 0, 0);
  endtask

  task automatic t_zero_tag();
    drive(0, '0, '0, '0, '0, 1, 4'd0, 32'hDEAD_BEEF);
    read2(4'd1, 4'd3);
    expect_src("R10", 0, 0, 32'h0000_AAAA, 0);
  endtask

  task automatic t_selective();
    drive(1, 4'd0, 4'd0, 4'd8, 4'd12, 0, '0, '0);
    drive(1, 4'd0, 4'd0, 4'd9, 4'd13, 0, '0, '0);
    drive(0, '0, '0, '0, '0, 1, 4'd12, 32'h6666_6666);
    read2(4'd8, 4'd9);
    expect_src("R7", 32'h6666_6666, 0, 0, 13);
  endtask

  task automatic t_self_dst();
    drive(1, 4'd3, 4'd3, 4'd3, 4'd3, 0, '0, '0);
    expect_src("R5", 32'h0000_AAAA, 0, 32'h0000_AAAA, 0);
    read2(4'd3, 4'd0);
    expect_src("R5", 0, 3, 0, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    t_reset();
    t_single_producer();
    t_waw();
    t_bypass();
    t_issue_vs_bcast();
    t_zero_tag();
    t_selective();
    t_self_dst();
    idle();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule